// File: doc/BRIEF.md
# Four-Channel DMA Controller

This block moves data between I/O devices and memory on behalf of a processor. Software programs each of four channels with a start address, a transfer count and a mode, then unmasks it. When a device raises its request line, or software sets the channel's request bit, the controller asks the bus arbiter for the bus and waits for the grant. It then drives one address per cycle with a read or write strobe, updating the address and the count after each transfer, until the mode's stop condition is met.

Each channel has a single, block or demand mode. A channel's count runs down through zero. The transfer made while the count is zero is the last one, and terminal count is signalled during that transfer. A channel can reload itself from its programmed base values at terminal count, or mask itself off. A per-channel status flag records terminal count and drives a shared interrupt line. Reading the status clears the flags.

Register map: `reg_addr[4]` = 1 selects the status register. Otherwise `reg_addr[3:2]` selects the channel and `reg_addr[1:0]` selects the field: 0 address, 1 count, 2 mode, 3 control. A write to the address or count field loads both the base copy and the working copy. A read of those fields returns the working value. The mode field bits are: bit 0 direction (1 = memory read toward the device, 0 = memory write from the device), bit 1 decrement (1 = address counts down), bit 2 auto-reload, bits 4:3 transfer kind (0 single, 1 block, 2 demand, 3 behaves as single). The control field bits are: bit 0 mask, bit 1 software request. Status bits 3:0 hold the terminal-count flags of channels 3..0.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset `hold_req`, `dack`, `mem_rd`, `mem_wr`, `tc` and `irq` are low, every channel is masked (control field reads 1), and the status register reads 0.
- R2: When a channel is selected, `hold_req` rises first. No `dack`, strobe or address is driven until `hold_ack` has been sampled high. The first transfer is in the cycle after `hold_ack` is sampled.
- R3: When several unmasked channels are pending in the same idle cycle, the lowest-numbered one is granted. `dack` is one-hot on the granted channel during each transfer cycle.
- R4: During a transfer `bus_addr` is the channel's working address and the strobe is `mem_rd` when mode bit 0 is 1, otherwise `mem_wr`. After the transfer the address is incremented by one, or decremented when mode bit 1 is 1.
- R5: A programmed count of N gives N+1 transfers. `tc` is high only during the transfer made while the count is zero, after which the count wraps to FFFFh.
- R6: In single mode each bus grant carries exactly one transfer, and then `hold_req` drops.
- R7: In block mode the channel keeps the bus until terminal count, even if its request line drops.
- R8: In demand mode the transfers stop when the request is sampled low during a transfer, and they resume later from the address and count they had reached.
- R9: `eop` sampled high during a transfer ends the bus ownership after that transfer and clears the channel's software request.
- R10: At terminal count, a channel with mode bit 2 set reloads its address and count from the base copies and stays unmasked. Without bit 2 the channel's mask bit is set.
- R11: Requests from a masked channel are ignored: no `hold_req` is raised for them.
- R12: Writing 1 to control bit 1 starts the channel without a hardware request. The bit clears at terminal count.
- R13: Terminal count sets the channel's status flag. `irq` is the OR of the flags. A status read clears them, but a flag set in the same cycle is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| reg_addr | input | 5 | Register select |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (status read clears flags) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| dreq | input | 4 | Device request lines, one per channel |
| dack | output | 4 | Device acknowledge, one-hot during transfers |
| hold_req | output | 1 | Bus request to the arbiter |
| hold_ack | input | 1 | Bus grant from the arbiter |
| eop | input | 1 | External end-of-process |
| bus_addr | output | 16 | Memory address during a transfer |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal count, high during the last transfer |
| irq | output | 1 | Interrupt, OR of the terminal-count flags |

## Verification
The assertions assume that the arbiter raises `hold_ack` only while `hold_req` is high and keeps the bus granted until `hold_req` falls. They also assume that software does not rewrite a channel's registers while that channel owns the bus. The bench's arbiter model derives `hold_ack` from `hold_req` one step later, and it can hold the grant back to stretch the wait. All register programming happens while the bus is idle. `eop` and request changes are the only inputs that move during bus ownership, so each stop rule of each transfer kind is reached through its own input pattern.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HOLD = 2'd1,
    ST_MOVE = 2'd2
  } seq_state_e;

  localparam logic [1:0] XM_SINGLE = 2'd0;
  localparam logic [1:0] XM_BLOCK  = 2'd1;
  localparam logic [1:0] XM_DEMAND = 2'd2;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_MODE = 2'd2;
  localparam logic [1:0] FLD_CTRL = 2'd3;

  typedef struct packed {
    logic [1:0] xmode;
    logic       auto_init;
    logic       dec;
    logic       dir;
  } chan_mode_t;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_addr,
  input  logic         wr_cnt,
  input  logic         wr_mode,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  input  logic         step,
  input  logic         eop,
  input  logic         stat_clr,
  input  logic         dreq,
  output logic [W-1:0] cur_addr,
  output logic [W-1:0] cur_cnt,
  output chan_mode_t   mode,
  output logic         mask,
  output logic         sreq,
  output logic         at_zero,
  output logic         want,
  output logic         pend,
  output logic         stat
);
  localparam int MW = $bits(chan_mode_t);

  logic [W-1:0] base_addr_q, base_addr_d, base_cnt_q, base_cnt_d;
  logic [W-1:0] addr_q, addr_d, cnt_q, cnt_d;
  chan_mode_t   mode_q, mode_d;
  logic         mask_q, mask_d, sreq_q, sreq_d, stat_q, stat_d;
  logic         last;

  assign at_zero = (cnt_q == '0);
  assign last    = step & at_zero;

  always_comb begin
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    addr_d      = addr_q;
    cnt_d       = cnt_q;
    mode_d      = mode_q;
    mask_d      = mask_q;
    sreq_d      = sreq_q;
    stat_d      = stat_q;
    if (stat_clr) stat_d = 1'b0;
    if (step) begin
      addr_d = mode_q.dec ? addr_q - W'(1) : addr_q + W'(1);
      cnt_d  = cnt_q - W'(1);
      if (last) begin
        stat_d = 1'b1;
        sreq_d = 1'b0;
        if (mode_q.auto_init) begin
          addr_d = base_addr_q;
          cnt_d  = base_cnt_q;
        end else begin
          mask_d = 1'b1;
        end
      end else if (eop) begin
        sreq_d = 1'b0;
      end
    end
    if (wr_addr) begin
      base_addr_d = wdata;
      addr_d      = wdata;
    end
    if (wr_cnt) begin
      base_cnt_d = wdata;
      cnt_d      = wdata;
    end
    if (wr_mode) mode_d = chan_mode_t'(wdata[MW-1:0]);
    if (wr_ctrl) begin
      mask_d = wdata[0];
      sreq_d = wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      addr_q      <= '0;
      cnt_q       <= '0;
      mode_q      <= '0;
      mask_q      <= 1'b1;
      sreq_q      <= 1'b0;
      stat_q      <= 1'b0;
    end else begin
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      addr_q      <= addr_d;
      cnt_q       <= cnt_d;
      mode_q      <= mode_d;
      mask_q      <= mask_d;
      sreq_q      <= sreq_d;
      stat_q      <= stat_d;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign mode     = mode_q;
  assign mask     = mask_q;
  assign sreq     = sreq_q;
  assign want     = dreq | sreq_q;
  assign pend     = want & ~mask_q;
  assign stat     = stat_q;

  assert_mask_at_tc_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && !mode_q.auto_init && !wr_ctrl) |=> mask_q);

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero && mode_q.auto_init && !wr_addr && !wr_cnt)
      |=> (addr_q == $past(base_addr_q) && cnt_q == $past(base_cnt_q)));

  assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_zero && !wr_cnt) |=> (cnt_q == $past(cnt_q) - W'(1)));

  assert_tc_flag_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_zero) |=> stat_q);
endmodule

// File: rtl/dma4_arb.sv
module dma4_arb #(
  parameter int N   = 4,
  parameter int CIW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]   pend,
  output logic [CIW-1:0] win,
  output logic           any
);
  always_comb begin
    win = '0;
    any = |pend;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) win = CIW'(i);
    end
  end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int CIW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           any,
  input  logic [CIW-1:0] win,
  input  logic           hack,
  input  logic           eop,
  input  logic [1:0]     act_xmode,
  input  logic           act_want,
  input  logic           act_zero,
  output seq_state_e     state,
  output logic [CIW-1:0] act,
  output logic           step
);
  seq_state_e     state_q, state_d;
  logic [CIW-1:0] act_q, act_d;
  logic           stop;

  always_comb begin
    stop = act_zero | eop;
    case (act_xmode)
      XM_BLOCK:  ;
      XM_DEMAND: stop = stop | ~act_want;
      default:   stop = 1'b1;
    endcase
  end

  always_comb begin
    state_d = state_q;
    act_d   = act_q;
    case (state_q)
      ST_IDLE: if (any) begin
        state_d = ST_HOLD;
        act_d   = win;
      end
      ST_HOLD: if (hack) state_d = ST_MOVE;
      ST_MOVE: if (stop) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      act_q   <= '0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
    end
  end

  assign state = state_q;
  assign act   = act_q;
  assign step  = (state_q == ST_MOVE);

  assert_move_after_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state_q == ST_MOVE) |-> $past(hack));

  assert_single_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVE && act_xmode == XM_SINGLE) |=> (state_q == ST_IDLE));

  assert_block_keeps_bus_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MOVE && act_xmode == XM_BLOCK && !act_zero && !eop)
      |=> (state_q == ST_MOVE));
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  parameter int W   = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [$clog2(NCH)+2:0] reg_addr,
  input  logic                  reg_we,
  input  logic                  reg_re,
  input  logic [W-1:0]          reg_wdata,
  output logic [W-1:0]          reg_rdata,
  input  logic [NCH-1:0]        dreq,
  output logic [NCH-1:0]        dack,
  output logic                  hold_req,
  input  logic                  hold_ack,
  input  logic                  eop,
  output logic [W-1:0]          bus_addr,
  output logic                  mem_rd,
  output logic                  mem_wr,
  output logic                  tc,
  output logic                  irq
);
  localparam int CIW = $clog2(NCH);
  localparam int RAW = CIW + 3;
  localparam int MW  = $bits(chan_mode_t);

  logic rst_meta, rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  logic           sel_stat;
  logic [CIW-1:0] sel_ch;
  logic [1:0]     fld;
  assign sel_stat = reg_addr[RAW-1];
  assign sel_ch   = reg_addr[RAW-2:2];
  assign fld      = reg_addr[1:0];

  logic [W-1:0]   addr_a [NCH];
  logic [W-1:0]   cnt_a  [NCH];
  chan_mode_t     mode_a [NCH];
  logic [NCH-1:0] mask_v, sreq_v, zero_v, want_v, pend_v, stat_v;

  seq_state_e     state;
  logic [CIW-1:0] act, win;
  logic           step, any, in_move;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = reg_we & ~sel_stat & (sel_ch == CIW'(c));
    dma4_chan #(.W(W)) u_chan (
      .clk     (clk),
      .rst_n   (rst_i),
      .wr_addr (hit & (fld == FLD_ADDR)),
      .wr_cnt  (hit & (fld == FLD_CNT)),
      .wr_mode (hit & (fld == FLD_MODE)),
      .wr_ctrl (hit & (fld == FLD_CTRL)),
      .wdata   (reg_wdata),
      .step    (step & (act == CIW'(c))),
      .eop     (eop),
      .stat_clr(reg_re & sel_stat),
      .dreq    (dreq[c]),
      .cur_addr(addr_a[c]),
      .cur_cnt (cnt_a[c]),
      .mode    (mode_a[c]),
      .mask    (mask_v[c]),
      .sreq    (sreq_v[c]),
      .at_zero (zero_v[c]),
      .want    (want_v[c]),
      .pend    (pend_v[c]),
      .stat    (stat_v[c])
    );
  end

  dma4_arb #(.N(NCH), .CIW(CIW)) u_arb (
    .pend(pend_v),
    .win (win),
    .any (any)
  );

  dma4_seq #(.CIW(CIW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_i),
    .any      (any),
    .win      (win),
    .hack     (hold_ack),
    .eop      (eop),
    .act_xmode(mode_a[act].xmode),
    .act_want (want_v[act]),
    .act_zero (zero_v[act]),
    .state    (state),
    .act      (act),
    .step     (step)
  );

  always_comb begin
    reg_rdata = '0;
    if (sel_stat) begin
      reg_rdata[NCH-1:0] = stat_v;
    end else begin
      case (fld)
        FLD_ADDR: reg_rdata = addr_a[sel_ch];
        FLD_CNT:  reg_rdata = cnt_a[sel_ch];
        FLD_MODE: reg_rdata[MW-1:0] = mode_a[sel_ch];
        default:  reg_rdata[1:0] = {sreq_v[sel_ch], mask_v[sel_ch]};
      endcase
    end
  end

  assign in_move  = (state == ST_MOVE);
  assign hold_req = (state != ST_IDLE);
  assign dack     = in_move ? (NCH'(1) << act) : '0;
  assign bus_addr = in_move ? addr_a[act] : '0;
  assign mem_rd   = in_move & mode_a[act].dir;
  assign mem_wr   = in_move & ~mode_a[act].dir;
  assign tc       = in_move & zero_v[act];
  assign irq      = |stat_v;

  assert_dack_onehot_R3: assert property (@(posedge clk) disable iff (!rst_i)
    $onehot0(dack));

  assert_irq_after_tc_R13: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(irq) |-> $past(tc));

  assert_eop_ends_R9: assert property (@(posedge clk) disable iff (!rst_i)
    (|dack && eop) |=> (dack == '0));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_i)
    !(mem_rd && mem_wr));
endmodule

// File: tb/dma4_ctrl_tb.sv
module dma4_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  reg_addr;
  logic        reg_we, reg_re;
  logic [15:0] reg_wdata, reg_rdata;
  logic [3:0]  dreq, dack;
  logic        hold_req, hold_ack, eop;
  logic [15:0] bus_addr;
  logic        mem_rd, mem_wr, tc, irq;

  always #10 clk = ~clk;

  dma4_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we), .reg_re(reg_re),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dreq(dreq), .dack(dack),
    .hold_req(hold_req), .hold_ack(hold_ack), .eop(eop), .bus_addr(bus_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .tc(tc), .irq(irq)
  );

  int    nchk = 0, nfail = 0, nxf = 0;
  string scen = "R1 reset";
  bit    ack_en = 1'b1;
  logic [3:0] first_dack;

  task automatic chk(input bit ok, input string tag, input logic [31:0] a, input logic [31:0] e);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s [%s] got %0h expected %0h", tag, scen, a, e);
    end
  endtask

  // bus arbiter model
  always @(posedge clk) begin
    #2 hold_ack = hold_req & ack_en;
  end

  // behavioural reference model
  int         m_st, m_act;
  logic [15:0] m_ca [4];
  logic [15:0] m_ba [4];
  logic [15:0] m_cc [4];
  logic [15:0] m_bc [4];
  logic [4:0]  m_md [4];
  bit          m_mk [4];
  bit          m_sr [4];
  bit          m_sf [4];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_act = 0;
      for (int i = 0; i < 4; i++) begin
        m_ca[i] = 0; m_ba[i] = 0; m_cc[i] = 0; m_bc[i] = 0; m_md[i] = 0;
        m_mk[i] = 1; m_sr[i] = 0; m_sf[i] = 0;
      end
    end else begin
      logic [3:0]  e_dack;
      logic [15:0] e_addr, e_rd;
      bit e_hreq, e_mrd, e_mwr, e_tc, e_irq;
      int nst, nact, xm;
      bit z, stop;
      e_hreq = (m_st != 0);
      e_dack = (m_st == 2) ? (4'b1 << m_act) : 4'b0;
      e_addr = (m_st == 2) ? m_ca[m_act] : 16'h0;
      e_mrd  = (m_st == 2) && m_md[m_act][0];
      e_mwr  = (m_st == 2) && !m_md[m_act][0];
      e_tc   = (m_st == 2) && (m_cc[m_act] == 0);
      e_irq  = m_sf[0] | m_sf[1] | m_sf[2] | m_sf[3];
      chk(hold_req === e_hreq, "R2", hold_req, e_hreq);
      chk(dack === e_dack, "R3", dack, e_dack);
      chk(bus_addr === e_addr, "R4", bus_addr, e_addr);
      chk(mem_rd === e_mrd && mem_wr === e_mwr, "R4", {mem_rd, mem_wr}, {e_mrd, e_mwr});
      chk(tc === e_tc, "R5", tc, e_tc);
      chk(irq === e_irq, "R13", irq, e_irq);
      if (reg_re) begin
        if (reg_addr[4]) e_rd = {12'h0, m_sf[3], m_sf[2], m_sf[1], m_sf[0]};
        else case (reg_addr[1:0])
          2'd0: e_rd = m_ca[reg_addr[3:2]];
          2'd1: e_rd = m_cc[reg_addr[3:2]];
          2'd2: e_rd = {11'h0, m_md[reg_addr[3:2]]};
          default: e_rd = {14'h0, m_sr[reg_addr[3:2]], m_mk[reg_addr[3:2]]};
        endcase
        chk(reg_rdata === e_rd, "R10", reg_rdata, e_rd);
      end
      if (|dack) begin
        if (nxf == 0) first_dack = dack;
        nxf++;
      end
      // next state
      nst = m_st; nact = m_act;
      if (reg_re && reg_addr[4]) for (int i = 0; i < 4; i++) m_sf[i] = 0;
      if (m_st == 0) begin
        for (int i = 3; i >= 0; i--)
          if (!m_mk[i] && (dreq[i] || m_sr[i])) begin nst = 1; nact = i; end
      end else if (m_st == 1) begin
        if (hold_ack) nst = 2;
      end else begin
        xm = int'(m_md[m_act][4:3]);
        z = (m_cc[m_act] == 0);
        stop = z || eop || xm == 0 || xm == 3 || (xm == 2 && !(dreq[m_act] || m_sr[m_act]));
        if (stop) nst = 0;
        if (m_md[m_act][1]) m_ca[m_act] = m_ca[m_act] - 1;
        else                m_ca[m_act] = m_ca[m_act] + 1;
        m_cc[m_act] = m_cc[m_act] - 1;
        if (z) begin
          m_sf[m_act] = 1; m_sr[m_act] = 0;
          if (m_md[m_act][2]) begin m_ca[m_act] = m_ba[m_act]; m_cc[m_act] = m_bc[m_act]; end
          else m_mk[m_act] = 1;
        end else if (eop) m_sr[m_act] = 0;
      end
      if (reg_we && !reg_addr[4]) begin
        case (reg_addr[1:0])
          2'd0: begin m_ca[reg_addr[3:2]] = reg_wdata; m_ba[reg_addr[3:2]] = reg_wdata; end
          2'd1: begin m_cc[reg_addr[3:2]] = reg_wdata; m_bc[reg_addr[3:2]] = reg_wdata; end
          2'd2: m_md[reg_addr[3:2]] = reg_wdata[4:0];
          default: begin m_mk[reg_addr[3:2]] = reg_wdata[0]; m_sr[reg_addr[3:2]] = reg_wdata[1]; end
        endcase
      end
      m_st = nst; m_act = nact;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    idle(1);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a);
    reg_addr = a; reg_re = 1'b1;
    idle(1);
    reg_re = 1'b0;
  endtask

  function automatic logic [15:0] mw(input int xm, input bit au, input bit dec, input bit dir);
    return 16'(xm << 3) | {13'h0, au, dec, dir};
  endfunction

  task automatic prog(input int ch, input logic [15:0] a, input logic [15:0] n, input logic [15:0] m);
    wr(5'(ch * 4 + 0), a);
    wr(5'(ch * 4 + 1), n);
    wr(5'(ch * 4 + 2), m);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog [%s] got 0 expected 1", scen);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_addr = '0; reg_we = 1'b0; reg_re = 1'b0; reg_wdata = '0;
    dreq = '0; eop = 1'b0; hold_ack = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle(4);

    scen = "R1 reset";
    chk(hold_req == 0 && dack == 0 && irq == 0 && tc == 0, "R1", {hold_req, dack, irq, tc}, 0);
    rd(5'd3); rd(5'd15); rd(5'd16);

    scen = "R11 masked";
    dreq[1] = 1'b1; idle(6);
    chk(hold_req == 0, "R11", hold_req, 0);
    dreq[1] = 1'b0; idle(1);

    scen = "R6 single, R4 increment read, R5 count";
    prog(1, 16'h0100, 16'd2, mw(0, 0, 0, 1));
    wr(5'd7, 16'd0);
    nxf = 0; dreq[1] = 1'b1; idle(20); dreq[1] = 1'b0; idle(2);
    chk(nxf == 3, "R5", nxf, 3);
    scen = "R10 mask after tc";
    rd(5'd7);
    scen = "R13 status";
    chk(irq == 1, "R13", irq, 1);
    rd(5'd16);
    chk(irq == 0, "R13", irq, 0);

    scen = "R7 block, R4 decrement write, R2 wait";
    prog(2, 16'h0200, 16'd4, mw(1, 0, 1, 0));
    wr(5'd11, 16'd0);
    ack_en = 1'b0; nxf = 0;
    dreq[2] = 1'b1; idle(2); dreq[2] = 1'b0; idle(4);
    chk(hold_req == 1 && dack == 0, "R2", {hold_req, dack}, 5'h10);
    ack_en = 1'b1; idle(12);
    chk(nxf == 5, "R7", nxf, 5);
    rd(5'd8); rd(5'd16);

    scen = "R8 demand";
    prog(3, 16'h0300, 16'd5, mw(2, 0, 0, 1));
    wr(5'd15, 16'd0);
    nxf = 0;
    dreq[3] = 1'b1; idle(4); dreq[3] = 1'b0; idle(4);
    chk(nxf < 6, "R8", nxf, 6);
    rd(5'd12);
    dreq[3] = 1'b1; idle(12); dreq[3] = 1'b0; idle(2);
    chk(nxf == 6, "R8", nxf, 6);
    rd(5'd16);

    scen = "R9 end of process";
    prog(0, 16'h0010, 16'd20, mw(1, 0, 0, 0));
    wr(5'd3, 16'd0);
    nxf = 0;
    dreq[0] = 1'b1; idle(2); dreq[0] = 1'b0; idle(4);
    eop = 1'b1; idle(1); eop = 1'b0; idle(4);
    chk(nxf < 21 && dack == 0, "R9", nxf, 21);
    rd(5'd1);
    wr(5'd3, 16'd1);

    scen = "R10 auto reload";
    prog(1, 16'h0040, 16'd1, mw(1, 1, 0, 1));
    wr(5'd7, 16'd0);
    nxf = 0;
    dreq[1] = 1'b1; idle(2); dreq[1] = 1'b0; idle(6);
    rd(5'd4); rd(5'd5); rd(5'd7);
    dreq[1] = 1'b1; idle(2); dreq[1] = 1'b0; idle(6);
    chk(nxf == 4, "R10", nxf, 4);
    wr(5'd7, 16'd1);
    rd(5'd16);

    scen = "R3 priority";
    prog(0, 16'h0500, 16'd1, mw(0, 0, 0, 0));
    prog(2, 16'h0600, 16'd1, mw(0, 0, 0, 1));
    wr(5'd3, 16'd0); wr(5'd11, 16'd0);
    nxf = 0; first_dack = '0;
    dreq = 4'b0101; idle(20); dreq = '0; idle(2);
    chk(first_dack == 4'b0001, "R3", first_dack, 1);
    chk(nxf == 4, "R3", nxf, 4);
    rd(5'd16);

    scen = "R12 software request";
    prog(3, 16'h0700, 16'd2, mw(1, 0, 1, 0));
    nxf = 0;
    wr(5'd15, 16'd2);
    idle(10);
    chk(nxf == 3, "R12", nxf, 3);
    rd(5'd15);
    scen = "R13 status clear";
    chk(irq == 1, "R13", irq, 1);
    rd(5'd16);
    chk(irq == 0, "R13", irq, 0);
    idle(2);
    finish_run();
  end
endmodule